// File: doc/BRIEF.md
# Per-Line MOESI Snoop Coherence Controller

This block holds the coherence state of one line in a private write-back cache attached to a shared snooping bus. It accepts load, store and evict commands from the local processor and snooped transactions from other caches. When the line must change hands, it raises a single bus request and holds it until the bus grants it.

The line can be Invalid, Shared, Exclusive-clean, Owned or Modified. Every bus transaction completes atomically in its grant cycle, so there are no transient states. Invalidation is used instead of update. A store to an Exclusive-clean line turns it dirty without any bus traffic. A Modified line that another cache reads becomes Owned: it keeps the dirty data, answers later reads in place of memory, and writes the data back only when it is evicted.

The snoop responses (has-copy, has-dirty-copy, supply-data) are combinational from the current state and the snooped command, so that the bus can combine them in the same cycle. A snoop always takes precedence over local activity in the cycle it appears.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset the line is Invalid, no bus request or writeback is raised, and `cpu_ready` is high. The `line_state` encoding is 0 Invalid, 1 Shared, 2 Exclusive-clean, 3 Owned, 4 Modified.
- R2: A load (op 0) to a valid line completes with no bus request. A load to an Invalid line raises a read request (`bus_req` 2'b01). At its grant the line fills as Exclusive-clean when `bus_shared_in` is low and as Shared when it is high.
- R3: A store (op 1) to an Invalid line raises a read-exclusive request (2'b10), and the line becomes Modified at its grant.
- R4: A store to a Shared or Owned line raises an upgrade request (2'b11) with no data transfer, and the line becomes Modified at its grant.
- R5: A store to an Exclusive-clean or Modified line leaves `bus_req` at 2'b00 and completes in the following cycle with the line Modified.
- R6: A snooped read (`snp_cmd` 2'b01) asserts `snp_has_copy` for any valid line and `snp_has_dirty` only for Owned or Modified. It moves Exclusive-clean to Shared and Modified to Owned, and leaves Shared and Owned unchanged.
- R7: `snp_supply` is high during a snooped read or read-exclusive exactly when the line is Owned or Modified.
- R8: A snooped read-exclusive (2'b10) or upgrade (2'b11) sends any line to Invalid.
- R9: If a snooped invalidation hits while this line's own upgrade is pending, the pending request changes to read-exclusive.
- R10: An evict (op 2) of an Owned or Modified line pulses `bus_wb` for one cycle. An evict of a Shared or Exclusive-clean line is silent. Every evict leaves the line Invalid.
- R11: At most one bus request is pending. `bus_req` holds its value until `bus_gnt`, and `cpu_ready` is low while a request is pending or a snoop is present.
- R12: `cpu_done` pulses for one cycle after each accepted command completes: in the cycle after acceptance for hits and evicts, and in the cycle after the grant for misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor command valid |
| cpu_op | input | 2 | 0 load, 1 store, 2 evict |
| cpu_ready | output | 1 | Command can be accepted this cycle |
| cpu_done | output | 1 | Command completed (one-cycle pulse) |
| bus_req | output | 2 | Pending bus request: 00 none, 01 read, 10 read-exclusive, 11 upgrade |
| bus_gnt | input | 1 | Pending request performed this cycle |
| bus_shared_in | input | 1 | Another cache reported a copy during the granted read |
| bus_wb | output | 1 | Writeback strobe for dirty data |
| snp_valid | input | 1 | Snooped transaction from another cache present |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_req |
| snp_has_copy | output | 1 | This cache holds a valid copy |
| snp_has_dirty | output | 1 | This cache holds a dirty copy |
| snp_supply | output | 1 | This cache provides the data |
| line_state | output | 3 | Current line state |

## Verification
The bench targets the cases where a simpler protocol would do the wrong thing. A design without the Exclusive-clean shortcut would place an upgrade on the bus for a store after a lone read. A design that treated a snooped read of Modified like MSI would fall to Shared and lose ownership, so a later read would find no supplier and no dirty response. The bench also lets a foreign read-exclusive arrive while this line's own upgrade waits. A controller that kept the upgrade would then make a line Modified without fetching its data. Evicts are run from every valid state, which catches a design that writes back clean lines or drops the writeback for an Owned one.

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_valid,
  input  logic [1:0] cpu_op,
  output logic       cpu_ready,
  output logic       cpu_done,
  output logic [1:0] bus_req,
  input  logic       bus_gnt,
  input  logic       bus_shared_in,
  output logic       bus_wb,
  input  logic       snp_valid,
  input  logic [1:0] snp_cmd,
  output logic       snp_has_copy,
  output logic       snp_has_dirty,
  output logic       snp_supply,
  output logic [2:0] line_state
);

  localparam logic [2:0] ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4;
  localparam logic [1:0] RQ_NONE = 2'b00, RQ_RD = 2'b01, RQ_RDX = 2'b10, RQ_UPG = 2'b11;
  localparam logic [1:0] OP_LD = 2'd0, OP_ST = 2'd1, OP_EV = 2'd2;

  logic [2:0] st, st_nx;
  logic [1:0] pend, pend_nx;
  logic       done_q, done_nx;
  logic       wb_q, wb_nx;

  wire dirty   = (st == ST_M) || (st == ST_O);
  wire snp_rd  = snp_valid && (snp_cmd == RQ_RD);
  wire snp_inv = snp_valid && ((snp_cmd == RQ_RDX) || (snp_cmd == RQ_UPG));

  assign cpu_ready     = (pend == RQ_NONE) && !snp_valid;
  assign cpu_done      = done_q;
  assign bus_req       = pend;
  assign bus_wb        = wb_q;
  assign line_state    = st;
  assign snp_has_copy  = snp_rd && (st != ST_I);
  assign snp_has_dirty = snp_rd && dirty;
  assign snp_supply    = (snp_rd || (snp_valid && snp_cmd == RQ_RDX)) && dirty;

  always_comb begin
    st_nx   = st;
    pend_nx = pend;
    done_nx = 1'b0;
    wb_nx   = 1'b0;
    if (snp_rd) begin
      if (st == ST_E) st_nx = ST_S;
      else if (st == ST_M) st_nx = ST_O;
    end else if (snp_inv) begin
      st_nx = ST_I;
      if (pend == RQ_UPG) pend_nx = RQ_RDX;
    end else if (pend != RQ_NONE) begin
      if (bus_gnt) begin
        if (pend == RQ_RD) st_nx = bus_shared_in ? ST_S : ST_E;
        else st_nx = ST_M;
        pend_nx = RQ_NONE;
        done_nx = 1'b1;
      end
    end else if (cpu_valid) begin
      case (cpu_op)
        OP_LD: begin
          if (st == ST_I) pend_nx = RQ_RD;
          else done_nx = 1'b1;
        end
        OP_ST: begin
          if (st == ST_E || st == ST_M) begin
            st_nx   = ST_M;
            done_nx = 1'b1;
          end else if (st == ST_I) pend_nx = RQ_RDX;
          else pend_nx = RQ_UPG;
        end
        OP_EV: begin
          wb_nx   = dirty;
          st_nx   = ST_I;
          done_nx = 1'b1;
        end
        default: done_nx = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_I;
      pend   <= RQ_NONE;
      done_q <= 1'b0;
      wb_q   <= 1'b0;
    end else begin
      st     <= st_nx;
      pend   <= pend_nx;
      done_q <= done_nx;
      wb_q   <= wb_nx;
    end
  end

endmodule

// File: rtl/moesi_line_chk.sv
module moesi_line_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_valid,
  input logic [1:0] cpu_op,
  input logic       cpu_ready,
  input logic       cpu_done,
  input logic [1:0] bus_req,
  input logic       bus_gnt,
  input logic       bus_shared_in,
  input logic       bus_wb,
  input logic       snp_valid,
  input logic [1:0] snp_cmd,
  input logic       snp_has_copy,
  input logic       snp_has_dirty,
  input logic       snp_supply,
  input logic [2:0] line_state
);

  // R2
  read_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_req == 2'b01 && !snp_valid) |=>
      (line_state == ($past(bus_shared_in) ? 3'd1 : 3'd2)));

  // R3
  rdx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_gnt && bus_req == 2'b10 && !snp_valid) |=> (line_state == 3'd4));

  // R5
  silent_upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && cpu_ready && cpu_op == 2'd1 && line_state == 3'd2) |=>
      (line_state == 3'd4 && bus_req == 2'b00));

  // R6
  dirty_has_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_has_dirty |-> snp_has_copy);

  // R6
  take_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 2'b01 && line_state == 3'd4) |=> (line_state == 3'd3));

  // R8
  snoop_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd[1]) |=> (line_state == 3'd0));

  // R10
  wb_dirty_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wb |-> (line_state == 3'd0 && ($past(line_state) == 3'd3 || $past(line_state) == 3'd4)));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req != 2'b00 && !bus_gnt && !snp_valid) |=> (bus_req == $past(bus_req)));

  // R11
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req != 2'b00) |-> !cpu_ready);

endmodule

bind moesi_line_ctrl moesi_line_chk u_chk (.*);

// File: tb/moesi_line_ctrl_bench.sv
module moesi_line_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_valid = 1'b0;
  logic [1:0] cpu_op = 2'd0;
  logic       cpu_ready, cpu_done;
  logic [1:0] bus_req;
  logic       bus_gnt = 1'b0;
  logic       bus_shared_in = 1'b0;
  logic       bus_wb;
  logic       snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'b00;
  logic       snp_has_copy, snp_has_dirty, snp_supply;
  logic [2:0] line_state;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  moesi_line_ctrl u_moesi_line_ctrl (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: every completion pops the expected final state
  always @(negedge clk) begin
    if (rst_n && cpu_done) begin
      if (exp_q.size() == 0) chk("R12 unexpected done", 1, 0);
      else chk("R12 state at done", int'(line_state), exp_q.pop_front());
    end
  end

  // Driver: issues one command and queues its expected final state
  task automatic cpu_cmd(logic [1:0] op, int exp_state);
    while (!cpu_ready) @(negedge clk);
    cpu_valid = 1'b1;
    cpu_op    = op;
    exp_q.push_back(exp_state);
    @(negedge clk);
    cpu_valid = 1'b0;
  endtask

  task automatic grant(logic sh);
    bus_gnt = 1'b1;
    bus_shared_in = sh;
    @(negedge clk);
    bus_gnt = 1'b0;
    bus_shared_in = 1'b0;
  endtask

  task automatic snoop(logic [1:0] cmd, int c, int d, int s, string req);
    snp_valid = 1'b1;
    snp_cmd   = cmd;
    #1;
    chk({req, " has_copy"}, int'(snp_has_copy), c);
    chk({req, " has_dirty"}, int'(snp_has_dirty), d);
    chk({req, " supply"}, int'(snp_supply), s);
    chk("R11 ready low in snoop", int'(cpu_ready), 0);
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 state", int'(line_state), 0);
    chk("R1 bus_req", int'(bus_req), 0);
    chk("R1 wb", int'(bus_wb), 0);
    chk("R1 ready", int'(cpu_ready), 1);
    snoop(2'b01, 0, 0, 0, "R6 snoop on invalid");

    // R2 miss, no sharers -> E
    cpu_cmd(2'd0, 2);
    chk("R2 read request", int'(bus_req), 1);
    chk("R11 ready low pending", int'(cpu_ready), 0);
    @(negedge clk);
    chk("R11 request held", int'(bus_req), 1);
    grant(1'b0);
    chk("R2 fill exclusive", int'(line_state), 2);
    chk("R11 request cleared", int'(bus_req), 0);
    // R2 hit
    cpu_cmd(2'd0, 2);
    chk("R2 hit no request", int'(bus_req), 0);
    // R5 silent store on E
    cpu_cmd(2'd1, 4);
    chk("R5 no request", int'(bus_req), 0);
    chk("R5 modified", int'(line_state), 4);
    cpu_cmd(2'd1, 4);
    chk("R5 store on M no request", int'(bus_req), 0);
    // R6/R7 read of M -> O
    snoop(2'b01, 1, 1, 1, "R7 read of modified");
    chk("R6 modified to owned", int'(line_state), 3);
    snoop(2'b01, 1, 1, 1, "R7 read of owned");
    chk("R6 owned stays", int'(line_state), 3);
    // R10 evict O
    cpu_cmd(2'd2, 0);
    chk("R10 wb on owned", int'(bus_wb), 1);
    @(negedge clk);
    chk("R10 wb one cycle", int'(bus_wb), 0);

    // R2 miss with sharer -> S, R4 upgrade
    cpu_cmd(2'd0, 1);
    grant(1'b1);
    chk("R2 fill shared", int'(line_state), 1);
    snoop(2'b01, 1, 0, 0, "R6 read of shared");
    cpu_cmd(2'd1, 4);
    chk("R4 upgrade request", int'(bus_req), 3);
    grant(1'b0);
    chk("R4 modified", int'(line_state), 4);
    cpu_cmd(2'd2, 0);
    chk("R10 wb on modified", int'(bus_wb), 1);

    // E read by other -> S, silent evict
    cpu_cmd(2'd0, 2);
    grant(1'b0);
    snoop(2'b01, 1, 0, 0, "R6 read of exclusive");
    chk("R6 exclusive to shared", int'(line_state), 1);
    cpu_cmd(2'd2, 0);
    chk("R10 silent evict shared", int'(bus_wb), 0);
    cpu_cmd(2'd0, 2);
    grant(1'b0);
    cpu_cmd(2'd2, 0);
    chk("R10 silent evict exclusive", int'(bus_wb), 0);

    // R3 store miss, then R8 foreign rdx on M
    cpu_cmd(2'd1, 4);
    chk("R3 rdx request", int'(bus_req), 2);
    grant(1'b0);
    chk("R3 modified", int'(line_state), 4);
    snoop(2'b10, 0, 0, 1, "R7 rdx of modified");
    chk("R8 invalid after rdx", int'(line_state), 0);

    // R4 upgrade from O, R8 via upgrade snoop
    cpu_cmd(2'd1, 4);
    grant(1'b0);
    snoop(2'b01, 1, 1, 1, "R7 read before owned upgrade");
    cpu_cmd(2'd1, 4);
    chk("R4 owned upgrade", int'(bus_req), 3);
    grant(1'b0);
    cpu_cmd(2'd2, 0);
    cpu_cmd(2'd0, 1);
    grant(1'b1);
    snoop(2'b11, 0, 0, 0, "R8 upgrade snoop shared");
    chk("R8 invalid after upgrade", int'(line_state), 0);

    // R9 pending upgrade loses the line
    cpu_cmd(2'd0, 1);
    grant(1'b1);
    cpu_cmd(2'd1, 4);
    chk("R9 upgrade pending", int'(bus_req), 3);
    snoop(2'b10, 0, 0, 0, "R9 rdx during upgrade");
    chk("R9 line invalid", int'(line_state), 0);
    chk("R9 request now rdx", int'(bus_req), 2);
    grant(1'b0);
    chk("R9 modified after rdx", int'(line_state), 4);

    repeat (2) @(negedge clk);
    chk("R12 all completions seen", exp_q.size(), 0);
    finish_sim();
  end

endmodule